// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight status bits of an asynchronous serial port in one byte that the CPU can read and write. Events from the transmitter, the receiver and a DMA-style transfer engine set or clear the bits. Five of the bits report data and error conditions: transmit-empty, receive-full, overrun, framing error and parity error. Software can clear one of these only by writing 0 to it after a read has returned it as 1. Writing 1 to any of the five has no effect.

Of the remaining bits, transmit-end follows the transmitter and ignores every CPU write. The received multiprocessor bit is loaded by the receiver and is also read-only. The multiprocessor transmit bit is an ordinary read/write bit. Transmit-empty is forced to 1 while the transmitter is disabled, while the port is in standby, and from power-on reset.

Each clearable bit has its own arm latch. A CPU read loads every latch with the current flag value. The next CPU write uses the latches and then empties them, whether or not that write clears anything. When a hardware event sets a flag in the same cycle as a software clear, the set wins.

Top module: `serial_status_flags`

## Requirements
- R1: Bit layout from bit 7 down to bit 0 is: transmit-empty, receive-full, overrun, framing error, parity error, transmit-end, received multiprocessor bit, transmit multiprocessor bit. After reset the byte reads 0x84.
- R2: While `cpu_rd_i` is high, `cpu_rdata_o` equals the status byte in the same cycle, with no register in between.
- R3: A CPU write of 1 to any of bits 7 to 3 never sets that bit.
- R4: A CPU write of 0 to one of bits 7 to 3 clears it when the most recent CPU read returned that bit as 1 and no write has come between that read and this write. The clear is visible one clock later.
- R5: A CPU write of 0 to one of bits 7 to 3 that is not armed leaves it unchanged. Any CPU write empties all arm latches, including a write that clears nothing.
- R6: A pulse on `rx_full_set_i`, `overrun_set_i`, `frame_err_set_i` or `parity_err_set_i` sets the matching bit on the next clock, even if an armed clear of that bit arrives in the same cycle.
- R7: Bit 7 (transmit-empty) reads 1 on the clock after `tx_enable_i` is 0 or `standby_i` is 1, and stays 1 while either condition holds, even against an armed clear.
- R8: A pulse on `tx_shift_load_i` sets bit 7. A pulse on `dma_tx_fill_i` clears bit 7 when `dma_no_clear_i` is 0, and has no effect when `dma_no_clear_i` is 1.
- R9: Bit 2 (transmit-end) ignores CPU writes. `tx_end_set_i` sets it and `tx_end_clr_i` clears it, and set wins when both are high.
- R10: Bit 1 takes `rx_mpb_val_i` when `rx_mpb_load_i` is high and ignores CPU writes. Bit 0 takes bit 0 of the write data on every CPU write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| standby_i | input | 1 | Port in standby |
| tx_enable_i | input | 1 | Transmitter enable level |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data (combinational) |
| status_o | output | 8 | Current status byte |
| tx_shift_load_i | input | 1 | Transmit data moved into the shift register |
| dma_tx_fill_i | input | 1 | Transfer engine wrote transmit data |
| dma_no_clear_i | input | 1 | Engine option that stops the fill from clearing transmit-empty |
| rx_full_set_i | input | 1 | Receiver has stored a byte |
| overrun_set_i | input | 1 | Receiver overrun |
| frame_err_set_i | input | 1 | Receiver framing error |
| parity_err_set_i | input | 1 | Receiver parity error |
| tx_end_set_i | input | 1 | Transmitter finished |
| tx_end_clr_i | input | 1 | Transmitter busy again |
| rx_mpb_load_i | input | 1 | Load strobe for the received multiprocessor bit |
| rx_mpb_val_i | input | 1 | Received multiprocessor bit value |

## Verification
Read data is due in the same cycle as the read strobe, so the bench samples it two nanoseconds after driving the strobe. Every other result shows on `status_o` one clock after the stimulus. The bench drives inputs on the falling edge, so a register result is due at the next falling edge. A behavioural reference model updates on each rising edge and is compared with `status_o` on every falling edge. Directed scenarios also check fixed expected bytes for arming, arm consumption, set-over-clear, forced transmit-empty and the read-only bits.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
   localparam int unsigned STAT_W   = 8;
   localparam int unsigned NUM_CLR  = 5;
   localparam int unsigned TXE_B    = 7;
   localparam int unsigned RXF_B    = 6;
   localparam int unsigned OVR_B    = 5;
   localparam int unsigned FER_B    = 4;
   localparam int unsigned PER_B    = 3;
   localparam int unsigned TEND_B   = 2;
   localparam int unsigned MPR_B    = 1;
   localparam int unsigned MPT_B    = 0;
   localparam int unsigned CLR_LO   = PER_B;
   localparam logic [STAT_W-1:0] RST_BYTE = (STAT_W'(1) << TXE_B) | (STAT_W'(1) << TEND_B);
endpackage

// File: rtl/ssf_clr_flag.sv
module ssf_clr_flag #(
   parameter bit RST_VAL  = 1'b0,
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   input  logic set_i,
   input  logic hwclr_i,
   input  logic force_i,
   output logic q_o
);
   logic q_r, arm_r, sw_clr;

   assign sw_clr = wr_i && !wbit_i && arm_r;
   assign q_o    = q_r;

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  q_r <= RST_VAL;
            else if (force_i || set_i)   q_r <= 1'b1;
            else if (sw_clr || hwclr_i)  q_r <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  q_r <= RST_VAL;
            else if (force_i)            q_r <= 1'b1;
            else if (sw_clr || hwclr_i)  q_r <= 1'b0;
            else if (set_i)              q_r <= 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     arm_r <= 1'b0;
      else if (rd_i)  arm_r <= q_r;
      else if (wr_i)  arm_r <= 1'b0;
   end

   // R3
   write_one_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wbit_i && !set_i && !force_i && !q_r) |=> !q_r);
   // R5
   unarmed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !arm_r && !hwclr_i && q_r) |=> q_r);
   // R5
   arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !rd_i) |=> !arm_r);
   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SET_WINS && set_i) |=> q_r);
   // R7
   force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_i |=> q_r);
endmodule

// File: rtl/ssf_plain_bits.sv
module ssf_plain_bits
   import ssf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [STAT_W-1:0] wdata_i,
   input  logic              tend_set_i,
   input  logic              tend_clr_i,
   input  logic              mpr_load_i,
   input  logic              mpr_val_i,
   output logic              tend_o,
   output logic              mpr_o,
   output logic              mpt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           tend_o <= RST_BYTE[TEND_B];
      else if (tend_set_i)  tend_o <= 1'b1;
      else if (tend_clr_i)  tend_o <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           mpr_o <= RST_BYTE[MPR_B];
      else if (mpr_load_i)  mpr_o <= mpr_val_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mpt_o <= RST_BYTE[MPT_B];
      else if (wr_i)  mpt_o <= wdata_i[MPT_B];
   end

   // R9
   tend_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && (wdata_i[TEND_B] != tend_o) && !tend_set_i && !tend_clr_i) |=> $stable(tend_o));
   // R10
   mpr_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && (wdata_i[MPR_B] != mpr_o) && !mpr_load_i) |=> $stable(mpr_o));
   // R10
   mpt_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (mpt_o == $past(wdata_i[MPT_B])));
endmodule

// File: rtl/serial_status_flags.sv
module serial_status_flags
   import ssf_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby_i,
   input  logic              tx_enable_i,
   input  logic              cpu_rd_i,
   input  logic              cpu_wr_i,
   input  logic [STAT_W-1:0] cpu_wdata_i,
   output logic [STAT_W-1:0] cpu_rdata_o,
   output logic [STAT_W-1:0] status_o,
   input  logic              tx_shift_load_i,
   input  logic              dma_tx_fill_i,
   input  logic              dma_no_clear_i,
   input  logic              rx_full_set_i,
   input  logic              overrun_set_i,
   input  logic              frame_err_set_i,
   input  logic              parity_err_set_i,
   input  logic              tx_end_set_i,
   input  logic              tx_end_clr_i,
   input  logic              rx_mpb_load_i,
   input  logic              rx_mpb_val_i
);
   localparam int unsigned CLR_HI = CLR_LO + NUM_CLR - 1;

   generate
      if (CLR_HI != TXE_B || STAT_W != 8) begin : g_bad_layout
         $error("serial_status_flags: clearable field must end at bit 7 of an 8-bit byte");
      end
   endgenerate

   logic [STAT_W-1:0] stat;
   logic [CLR_HI:CLR_LO] set_v, hwclr_v, force_v;

   always_comb begin
      set_v   = '0;
      hwclr_v = '0;
      force_v = '0;
      set_v[TXE_B]   = tx_shift_load_i;
      set_v[RXF_B]   = rx_full_set_i;
      set_v[OVR_B]   = overrun_set_i;
      set_v[FER_B]   = frame_err_set_i;
      set_v[PER_B]   = parity_err_set_i;
      hwclr_v[TXE_B] = dma_tx_fill_i && !dma_no_clear_i;
      force_v[TXE_B] = !tx_enable_i || standby_i;
   end

   for (genvar b = CLR_LO; b <= CLR_HI; b++) begin : g_clr
      ssf_clr_flag #(
         .RST_VAL  (RST_BYTE[b]),
         .SET_WINS (SET_WINS)
      ) u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .rd_i    (cpu_rd_i),
         .wr_i    (cpu_wr_i),
         .wbit_i  (cpu_wdata_i[b]),
         .set_i   (set_v[b]),
         .hwclr_i (hwclr_v[b]),
         .force_i (force_v[b]),
         .q_o     (stat[b])
      );
   end

   ssf_plain_bits u_plain (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (cpu_wr_i),
      .wdata_i    (cpu_wdata_i),
      .tend_set_i (tx_end_set_i),
      .tend_clr_i (tx_end_clr_i),
      .mpr_load_i (rx_mpb_load_i),
      .mpr_val_i  (rx_mpb_val_i),
      .tend_o     (stat[TEND_B]),
      .mpr_o      (stat[MPR_B]),
      .mpt_o      (stat[MPT_B])
   );

   assign status_o    = stat;
   assign cpu_rdata_o = cpu_rd_i ? stat : '0;

   // R8
   dma_fill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_tx_fill_i && !dma_no_clear_i && !tx_shift_load_i && tx_enable_i && !standby_i)
      |=> !status_o[TXE_B]);
   // R8
   dma_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_tx_fill_i && dma_no_clear_i && status_o[TXE_B] && !cpu_wr_i) |=> status_o[TXE_B]);
endmodule

// File: tb/serial_status_flags_bench.sv
module serial_status_flags_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic standby = 0, tx_en = 0, rd = 0, wr = 0;
   logic [7:0] wdata = 0;
   logic [7:0] rdata, status;
   logic tx_load = 0, dma_fill = 0, dma_nc = 0, rxf_s = 0, ovr_s = 0, fer_s = 0, per_s = 0;
   logic tend_s = 0, tend_c = 0, mpr_ld = 0, mpr_v = 0;

   integer checks = 0, failures = 0, cycles = 0;
   bit done = 0;
   bit mdl[8];
   bit arm[8];

   always #10 clk = ~clk;

   serial_status_flags u_serial_status_flags (
      .clk(clk), .rst_n(rst_n), .standby_i(standby), .tx_enable_i(tx_en),
      .cpu_rd_i(rd), .cpu_wr_i(wr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
      .status_o(status), .tx_shift_load_i(tx_load), .dma_tx_fill_i(dma_fill),
      .dma_no_clear_i(dma_nc), .rx_full_set_i(rxf_s), .overrun_set_i(ovr_s),
      .frame_err_set_i(fer_s), .parity_err_set_i(per_s), .tx_end_set_i(tend_s),
      .tx_end_clr_i(tend_c), .rx_mpb_load_i(mpr_ld), .rx_mpb_val_i(mpr_v));

   function automatic logic [7:0] mdl_byte();
      logic [7:0] v;
      for (int i = 0; i < 8; i++) v[i] = mdl[i];
      return v;
   endfunction

   // Behavioural reference: flags 7..3 clearable with arming, 2..0 plain.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin mdl[i] = 0; arm[i] = 0; end
         mdl[7] = 1; mdl[2] = 1;
      end else begin
         bit old[8];
         bit setv[8];
         for (int i = 0; i < 8; i++) begin old[i] = mdl[i]; setv[i] = 0; end
         setv[7] = tx_load; setv[6] = rxf_s; setv[5] = ovr_s; setv[4] = fer_s; setv[3] = per_s;
         for (int i = 3; i < 8; i++) begin
            bit frc, hclr;
            frc  = (i == 7) && (!tx_en || standby);
            hclr = (i == 7) && dma_fill && !dma_nc;
            if (frc || setv[i]) mdl[i] = 1;
            else if ((wr && !wdata[i] && arm[i]) || hclr) mdl[i] = 0;
            if (rd) arm[i] = old[i];
            else if (wr) arm[i] = 0;
         end
         if (tend_s) mdl[2] = 1; else if (tend_c) mdl[2] = 0;
         if (mpr_ld) mdl[1] = mpr_v;
         if (wr) mdl[0] = wdata[0];
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (status !== mdl_byte()) begin
            failures++;
            $display("FAIL R1 model compare: actual=%h expected=%h", status, mdl_byte());
         end
      end
   end

   task automatic expect_stat(input logic [7:0] exp, input string tag);
      checks++;
      if (status !== exp) begin
         failures++;
         $display("FAIL %s status: actual=%h expected=%h", tag, status, exp);
      end
   endtask

   task automatic cpu_read(input logic [7:0] exp);
      rd = 1;
      #2;
      checks++;
      if (rdata !== exp) begin
         failures++;
         $display("FAIL R2 read data: actual=%h expected=%h", rdata, exp);
      end
      @(negedge clk); rd = 0;
   endtask

   task automatic cpu_write(input logic [7:0] d);
      wr = 1; wdata = d;
      @(negedge clk); wr = 0;
   endtask

   task automatic pulse(ref logic s);
      s = 1;
      @(negedge clk); s = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      expect_stat(8'h84, "R1");             // R1 reset value
      tx_en = 1;
      pulse(rxf_s);
      expect_stat(8'hC4, "R6");             // R6 receive-full set
      cpu_write(8'h00);
      expect_stat(8'hC4, "R5");             // R5 unarmed write 0
      cpu_read(8'hC4);                      // R2
      cpu_write(8'h00);
      expect_stat(8'h04, "R4");             // R4 armed clears, tend kept (R9)
      cpu_write(8'hFF);
      expect_stat(8'h05, "R3");             // R3 write 1 sets nothing; R10 mpt=1, mpr kept
      pulse(ovr_s);
      cpu_read(8'h25);
      cpu_write(8'hFF);
      cpu_write(8'h01);
      expect_stat(8'h25, "R5");             // R5 arm consumed by earlier write
      cpu_read(8'h25);
      wr = 1; wdata = 8'h01; ovr_s = 1;
      @(negedge clk); wr = 0; ovr_s = 0;
      expect_stat(8'h25, "R6");             // R6 set beats clear
      cpu_read(8'h25);
      cpu_write(8'h01);
      expect_stat(8'h05, "R4");
      pulse(tx_load);
      expect_stat(8'h85, "R8");
      dma_nc = 1; pulse(dma_fill); dma_nc = 0;
      expect_stat(8'h85, "R8");             // R8 disable-select blocks clear
      pulse(dma_fill);
      expect_stat(8'h05, "R8");
      standby = 1;
      @(negedge clk);
      expect_stat(8'h85, "R7");
      cpu_read(8'h85);
      cpu_write(8'h01);
      expect_stat(8'h85, "R7");             // R7 forced against armed clear
      standby = 0;
      pulse(dma_fill);
      expect_stat(8'h05, "R8");
      tx_en = 0;
      @(negedge clk);
      expect_stat(8'h85, "R7");
      tx_en = 1;
      pulse(tend_c);
      expect_stat(8'h81, "R9");
      cpu_read(8'h81);
      cpu_write(8'hFF);
      expect_stat(8'h81, "R9");             // R9 write 1 to tend ignored
      pulse(tend_s);
      expect_stat(8'h85, "R9");
      mpr_v = 1; pulse(mpr_ld); mpr_v = 0;
      expect_stat(8'h87, "R10");
      cpu_write(8'h00);
      expect_stat(8'h86, "R10");            // R10 mpr kept, mpt cleared
      fer_s = 1; per_s = 1;
      @(negedge clk); fer_s = 0; per_s = 0;
      expect_stat(8'h9E, "R6");
      cpu_read(8'h9E);
      cpu_write(8'hEF);
      expect_stat(8'h8F, "R4");             // R4 only framing error cleared
      repeat (2) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog: actual=%0d expected<=5000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule